// File: doc/BRIEF.md
# Dual-Read Dual-Write Register File

This block holds fifteen 64-bit general registers for a single-cycle processor datapath. Two read ports, A and B, return stored words combinationally from a 4-bit register index. Two write ports, E and M, update registers on the rising clock edge. Port E takes the arithmetic result and port M takes the loaded value. Both write ports can act on the same edge.

Index 0xF is reserved as "no register" on every port. A read at 0xF returns zero, and a write at 0xF is dropped. Reads never see a write that lands on the same edge. The datapath this block serves never needs its own result back within one instruction, so no forwarding path exists.

Top module: `dual_port_regfile`

## Requirements
- R1: A synchronous reset (active-high `rst`, sampled on the rising edge) clears all fifteen registers to 0.
- R2: Read port A returns the word stored at index `rd_a_idx` combinationally, with no clock edge involved; read port B does the same for `rd_b_idx`.
- R3: A read at index 0xF returns 64'h0 on either read port.
- R4: When `wr_e_idx` is not 0xF, `wr_e_data` is stored into that register on the rising edge.
- R5: When `wr_m_idx` is not 0xF, `wr_m_data` is stored into that register on the rising edge.
- R6: A write port indexed 0xF changes no register.
- R7: Ports E and M indexing two different registers both update them on the same edge.
- R8: When ports E and M index the same register on one edge, the port M value is stored.
- R9: A read in the same cycle as a write to the same register returns the old value until the edge has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A register index (0xF = none) |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index (0xF = none) |
| rd_b_data | output | 64 | Read port B data |
| wr_e_idx | input | 4 | Write port E register index (0xF = none) |
| wr_e_data | input | 64 | Write port E data |
| wr_m_idx | input | 4 | Write port M register index (0xF = none) |
| wr_m_data | input | 64 | Write port M data |

## Verification
Several functions can fall in the same cycle:
- The two write ports can act on one edge, at different registers or at the same one.
- A read can happen in the cycle where a write to its register is pending.

Random cycles pick indices from a narrow range, including 0xF, so both kinds of overlap occur often. Directed cycles force each overlap on purpose.

A shadow array in the bench applies port E first and port M second on each edge. Reads are compared against this array both before and after the edge. This shows that the pre-edge value is returned, and that port M wins a collision.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned IDX_W  = 4;
    localparam int unsigned NREGS  = (1 << IDX_W) - 1;
    localparam logic [IDX_W-1:0] IDX_NONE = '1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_req_t;
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode
    import regfile_pkg::*;
(
    input  idx_t            idx,
    output logic [NREGS-1:0] hit
);
    always_comb begin
        hit = '0;
        for (int i = 0; i < NREGS; i++) begin
            hit[i] = (idx == idx_t'(i));
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
(
    input  word_t [NREGS-1:0] regs,
    input  idx_t              idx,
    output word_t             data
);
    always_comb begin
        data = '0;
        if (idx != IDX_NONE) begin
            data = regs[idx];
        end
    end

    always_comb begin
        if (idx == IDX_NONE) begin
            assert_none_reads_zero_R3: assert (data == '0);
        end
    end
endmodule

// File: rtl/dual_port_regfile.sv
module dual_port_regfile
    import regfile_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     rd_a_idx,
    output logic [WORD_W-1:0]    rd_a_data,
    input  logic [IDX_W-1:0]     rd_b_idx,
    output logic [WORD_W-1:0]    rd_b_data,
    input  logic [IDX_W-1:0]     wr_e_idx,
    input  logic [WORD_W-1:0]    wr_e_data,
    input  logic [IDX_W-1:0]     wr_m_idx,
    input  logic [WORD_W-1:0]    wr_m_data
);
    typedef struct packed {
        word_t [NREGS-1:0] regs;
    } state_t;

    state_t state_d, state_q;
    logic [NREGS-1:0] hit_e, hit_m;

    rf_write_decode u_dec_e (.idx(wr_e_idx), .hit(hit_e));
    rf_write_decode u_dec_m (.idx(wr_m_idx), .hit(hit_m));

    // Port M is applied last so it wins a collision.
    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NREGS; i++) begin
            if (hit_e[i]) state_d.regs[i] = wr_e_data;
            if (hit_m[i]) state_d.regs[i] = wr_m_data;
        end
        if (rst) state_d = '0;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    rf_read_port u_rd_a (.regs(state_q.regs), .idx(rd_a_idx), .data(rd_a_data));
    rf_read_port u_rd_b (.regs(state_q.regs), .idx(rd_b_idx), .data(rd_b_data));

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (rd_a_data == '0 && rd_b_data == '0));

    assert_write_e_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_e_idx != IDX_NONE && wr_m_idx != wr_e_idx && rd_a_idx == wr_e_idx)
        |=> ($stable(rd_a_idx) -> rd_a_data == $past(wr_e_data)));

    assert_write_m_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_m_idx != IDX_NONE && rd_b_idx == wr_m_idx)
        |=> ($stable(rd_b_idx) -> rd_b_data == $past(wr_m_data)));

    assert_no_write_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_e_idx == IDX_NONE && wr_m_idx == IDX_NONE)
        |=> ($stable(rd_a_idx) -> $stable(rd_a_data)));
endmodule

// File: tb/dual_port_regfile_bench.sv
module dual_port_regfile_bench;
    import regfile_pkg::*;

    logic clk = 0;
    logic rst;
    idx_t ra, rb, we, wm;
    word_t rda, rdb, wed, wmd;

    int checks = 0;
    int fails  = 0;
    word_t model [NREGS];

    dual_port_regfile u_dual_port_regfile (
        .clk(clk), .rst(rst),
        .rd_a_idx(ra), .rd_a_data(rda),
        .rd_b_idx(rb), .rd_b_data(rdb),
        .wr_e_idx(we), .wr_e_data(wed),
        .wr_m_idx(wm), .wr_m_data(wmd)
    );

    always #5 clk = ~clk;

    function automatic word_t expect_rd(idx_t i);
        return (i == IDX_NONE) ? '0 : model[i];
    endfunction

    task automatic check(string req, word_t act, word_t exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < NREGS; i++) model[i] = '0;
        end else begin
            if (we != IDX_NONE) model[we] = wed;
            if (wm != IDX_NONE) model[wm] = wmd;
        end
    endtask

    // drive at negedge, update model at posedge, sample 1 ns later
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 16; i++) begin
            ra = idx_t'(i);
            rb = idx_t'(15 - i);
            #1;
            check(req, rda, expect_rd(ra));
            check(req, rdb, expect_rd(rb));
        end
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        rst = 1; we = IDX_NONE; wm = IDX_NONE; wed = '0; wmd = '0; ra = 0; rb = 0;
        for (int i = 0; i < NREGS; i++) model[i] = 'x;
        @(negedge clk);
        step(); step();
        @(negedge clk);
        rst = 0;
        check_all("R1");
        // R7 dual write
        we = 4'd3; wed = 64'hAAAA_0000_0000_0003;
        wm = 4'd9; wmd = 64'h5555_0000_0000_0009;
        ra = 4'd3; rb = 4'd9;
        #1;
        check("R9", rda, 64'h0);
        check("R9", rdb, 64'h0);
        step();
        check("R7", rda, 64'hAAAA_0000_0000_0003);
        check("R7", rdb, 64'h5555_0000_0000_0009);
        // R8 collision
        @(negedge clk);
        we = 4'd5; wed = 64'h1111; wm = 4'd5; wmd = 64'h2222; ra = 4'd5;
        step();
        check("R8", rda, 64'h2222);
        // R6 suppressed writes
        @(negedge clk);
        we = IDX_NONE; wed = '1; wm = IDX_NONE; wmd = '1;
        step();
        @(negedge clk);
        check_all("R6");
        // R4/R5 single ports, R2 combinational change
        we = 4'd14; wed = 64'hDEAD_BEEF; wm = IDX_NONE;
        step();
        @(negedge clk);
        we = IDX_NONE; wm = 4'd0; wmd = 64'hCAFE;
        step();
        @(negedge clk);
        we = IDX_NONE; wm = IDX_NONE;
        ra = 4'd14; #1; check("R4", rda, 64'hDEAD_BEEF);
        rb = 4'd0;  #1; check("R5", rdb, 64'hCAFE);
        ra = 4'd0;  #1; check("R2", rda, 64'hCAFE);
        ra = IDX_NONE; #1; check("R3", rda, 64'h0);
        // random mix
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            we  = idx_t'($urandom_range(15, 10));
            wm  = idx_t'($urandom_range(15, 10));
            wed = {$urandom, $urandom};
            wmd = {$urandom, $urandom};
            ra  = idx_t'($urandom_range(15, 10));
            rb  = ($urandom_range(1, 0) == 1) ? wm : we;
            #1;
            check("R9", rda, expect_rd(ra));
            check("R9", rdb, expect_rd(rb));
            step();
            check((wm == rb) ? "R8" : "R4", rdb, expect_rd(rb));
            check("R2", rda, expect_rd(ra));
        end
        @(negedge clk);
        we = IDX_NONE; wm = IDX_NONE;
        check_all("R7");
        rst = 1;
        step();
        @(negedge clk);
        rst = 0;
        check_all("R1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule